// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block runs a small instruction set in which the arithmetic operations name no operands. Every operand lives on an on-chip stack of data words. An instruction arrives as a 3-bit opcode and an address, qualified by a valid strobe. Only the two memory operations use the address:

- A push fetches a word from data memory and places it on top of the stack.
- A pop removes the top word and stores it to memory.
- Add, subtract and multiply each consume the two topmost words and leave one result in their place.

The operand order is fixed: subtract yields the top word minus the word beneath it. A compiler can therefore evaluate an expression tree by emitting its leaves in post-order. For example, `A = B + C*D - E + F + A` becomes a twelve-instruction program that ends by popping into A.

The block talks to a data memory through a one-port interface. A read is synchronous and returns its word one cycle after the read strobe. Three registered status outputs report the block's condition:

- `busy` means an accepted memory instruction is still in flight. Instructions offered while it is high are not taken.
- `overflow` reports a push that was refused because the stack is full.
- `underflow` reports an operation that was refused because the stack held too few words.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset, busy, overflow, underflow, mem_rd_en and mem_wr_en are all low and the stack is empty, so a first pop reports underflow.
- R2: A push (opcode 0) accepted in cycle T drives mem_rd_en with mem_addr equal to the instruction address during cycle T+1. The returned word becomes the new top of stack. busy is high for exactly two cycles after acceptance.
- R3: A push onto a stack that already holds DEPTH words raises overflow, issues no memory read, leaves busy low and leaves the stack contents unchanged.
- R4: A pop (opcode 1) with at least one word stored drives mem_wr_en for one cycle after acceptance, with mem_addr equal to the instruction address and mem_wdata equal to the top word. It removes that word, and busy is high for that one cycle.
- R5: A pop on an empty stack raises underflow and performs no memory write.
- R6: Add (opcode 2) replaces the two top words with their 32-bit sum, completes at its acceptance edge and does not raise busy.
- R7: Subtract (opcode 3) replaces the two top words with top minus next, modulo 2^32.
- R8: Multiply (opcode 4) replaces the two top words with the low 32 bits of their product.
- R9: Add, subtract or multiply with fewer than two stored words raises underflow and leaves the stack unchanged.
- R10: An instruction offered while busy is high is not accepted. Opcodes 5 to 7 are accepted but change nothing: they cause no memory access and no flag.
- R11: overflow and underflow are held until the next instruction is accepted, and that acceptance clears them.
- R12: The post-order program push E, push C, push D, mul, push B, add, sub, push F, add, push A, add, pop A stores B+C*D-E+F+A to the address of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction offered this cycle |
| instr_op | input | 3 | Opcode: 0 push, 1 pop, 2 add, 3 sub, 4 mul, 5-7 no effect |
| instr_addr | input | AW (8) | Memory word address for push and pop |
| busy | output | 1 | Memory instruction in flight; new instructions are not taken |
| overflow | output | 1 | Last accepted instruction was a push refused on a full stack |
| underflow | output | 1 | Last accepted instruction was refused for lack of stack words |
| mem_addr | output | AW (8) | Data memory word address |
| mem_rd_en | output | 1 | Data memory read strobe |
| mem_wr_en | output | 1 | Data memory write strobe |
| mem_wdata | output | DW (32) | Data memory write word |
| mem_rdata | input | DW (32) | Data memory read word, valid one cycle after mem_rd_en |

## Verification
The assertions check the following on every cycle:
- A memory read and a memory write never occur together.
- A write strobe only appears while busy is high.
- A read is always followed by a busy capture cycle.
- The memory address holds steady across a busy interval.
- The stored word count never exceeds the depth.
- A refusal, whether overflow or underflow, never moves the count.

Only the bench scenarios can show the following:
- The data values that come out: operand order for subtract, truncation of the product, and the value of the full expression program.
- That a refused or ignored instruction really left the stack contents intact, which is seen through later pops.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_MUL  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_CAP  = 2'd2,
    ST_WR   = 2'd3
  } st_e;

  function automatic logic is_arith(input logic [2:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL);
  endfunction

endpackage

// File: rtl/stk_store.sv
module stk_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_top,
  input  logic [IW-1:0] ra_nxt,
  output logic [DW-1:0] rd_top,
  output logic [DW-1:0] rd_nxt
);

  logic [DW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (waddr == IW'(g))) ent[g] <= wdata;
    end
  end

  assign rd_top = ent[ra_top];
  assign rd_nxt = ent[ra_nxt];

endmodule

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DW = 32
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] top_w,
  input  logic [DW-1:0] nxt_w,
  output logic [DW-1:0] res
);
  import stk_pkg::*;

  logic [2*DW-1:0] prod;

  assign prod = top_w * nxt_w;

  always_comb begin
    case (op)
      OP_ADD:  res = top_w + nxt_w;
      OP_SUB:  res = top_w - nxt_w;
      OP_MUL:  res = prod[DW-1:0];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int DEPTH = 8,
  parameter int IW    = 3,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [2:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] top_w,
  input  logic [DW-1:0] alu_res,
  output logic          st_we,
  output logic [IW-1:0] st_waddr,
  output logic [DW-1:0] st_wdata,
  output logic [IW-1:0] ra_top,
  output logic [IW-1:0] ra_nxt,
  output logic          busy,
  output logic          overflow,
  output logic          underflow,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [DW-1:0] mem_wdata
);
  import stk_pkg::*;

  st_e           state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_m1;
  logic [CW-1:0] cnt_m2;
  logic          accept;
  logic          full;
  logic          has1;
  logic          has2;
  logic          arith_go;

  assign cnt_m1   = cnt - CW'(1);
  assign cnt_m2   = cnt - CW'(2);
  assign ra_top   = cnt_m1[IW-1:0];
  assign ra_nxt   = cnt_m2[IW-1:0];
  assign full     = (cnt == CW'(DEPTH));
  assign has1     = (cnt != '0);
  assign has2     = (cnt >= CW'(2));
  assign accept   = instr_valid && (state == ST_IDLE);
  assign arith_go = accept && is_arith(instr_op) && has2;

  // stack write port: captured memory word or arithmetic result
  always_comb begin
    st_we    = 1'b0;
    st_waddr = ra_nxt;
    st_wdata = alu_res;
    if (state == ST_CAP) begin
      st_we    = 1'b1;
      st_waddr = cnt[IW-1:0];
      st_wdata = mem_rdata;
    end else if (arith_go) begin
      st_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      busy      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
      mem_addr  <= '0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_wdata <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            overflow  <= 1'b0;
            underflow <= 1'b0;
            case (instr_op)
              OP_PUSH: begin
                if (full) begin
                  overflow <= 1'b1;
                end else begin
                  mem_addr  <= instr_addr;
                  mem_rd_en <= 1'b1;
                  busy      <= 1'b1;
                  state     <= ST_RD;
                end
              end
              OP_POP: begin
                if (!has1) begin
                  underflow <= 1'b1;
                end else begin
                  mem_addr  <= instr_addr;
                  mem_wdata <= top_w;
                  mem_wr_en <= 1'b1;
                  busy      <= 1'b1;
                  cnt       <= cnt_m1;
                  state     <= ST_WR;
                end
              end
              OP_ADD, OP_SUB, OP_MUL: begin
                if (!has2) underflow <= 1'b1;
                else       cnt       <= cnt_m1;
              end
              default: ;
            endcase
          end
        end
        ST_RD: begin
          mem_rd_en <= 1'b0;
          state     <= ST_CAP;
        end
        ST_CAP: begin
          cnt   <= cnt + CW'(1);
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        ST_WR: begin
          mem_wr_en <= 1'b0;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: read and write strobes never coincide
  p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));

  // R2: a read strobe is followed by a busy capture cycle without a second read
  p_rd_then_cap_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> (busy && !mem_rd_en));

  // R3: the stored count never exceeds the depth
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R3: a refused push moves nothing
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> ($stable(cnt) && !mem_rd_en));

  // R4: a write strobe only while busy
  p_wr_busy_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> busy);

  // R9: a refusal for lack of words leaves the count alone
  p_udf_hold_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(underflow) |-> ($stable(cnt) && !mem_wr_en));

  // R10: nothing new is taken while busy, so the address holds
  p_busy_addr_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mem_addr));

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  input  logic [2:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  output logic          busy,
  output logic          overflow,
  output logic          underflow,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd_en,
  output logic          mem_wr_en,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          st_we;
  logic [IW-1:0] st_waddr;
  logic [DW-1:0] st_wdata;
  logic [IW-1:0] ra_top;
  logic [IW-1:0] ra_nxt;
  logic [DW-1:0] top_w;
  logic [DW-1:0] nxt_w;
  logic [DW-1:0] alu_res;

  stk_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) store_i (
    .clk    (clk),
    .we     (st_we),
    .waddr  (st_waddr),
    .wdata  (st_wdata),
    .ra_top (ra_top),
    .ra_nxt (ra_nxt),
    .rd_top (top_w),
    .rd_nxt (nxt_w)
  );

  stk_alu #(.DW(DW)) alu_i (
    .op    (instr_op),
    .top_w (top_w),
    .nxt_w (nxt_w),
    .res   (alu_res)
  );

  stk_ctrl #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .IW(IW), .CW(CW)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_op    (instr_op),
    .instr_addr  (instr_addr),
    .mem_rdata   (mem_rdata),
    .top_w       (top_w),
    .alu_res     (alu_res),
    .st_we       (st_we),
    .st_waddr    (st_waddr),
    .st_wdata    (st_wdata),
    .ra_top      (ra_top),
    .ra_nxt      (ra_nxt),
    .busy        (busy),
    .overflow    (overflow),
    .underflow   (underflow),
    .mem_addr    (mem_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wdata   (mem_wdata)
  );

endmodule

// File: tb/stack_exec_unit_tb_top.sv
module stack_exec_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 8;
  localparam int MWORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          instr_valid = 1'b0;
  logic [2:0]    instr_op = '0;
  logic [AW-1:0] instr_addr = '0;
  logic          busy, overflow, underflow, mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] bmem [MWORDS];
  logic          pre_en = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] m_stk [DEPTH];
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_exec_unit #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_op(instr_op),
    .instr_addr(instr_addr), .busy(busy), .overflow(overflow),
    .underflow(underflow), .mem_addr(mem_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bench data memory with one-cycle synchronous read
  always @(posedge clk) begin
    if (pre_en) bmem[pre_addr] <= pre_data;
    else if (mem_wr_en) bmem[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= bmem[mem_addr];
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [DW-1:0] f_alu(input logic [2:0] op,
                                          input logic [DW-1:0] t,
                                          input logic [DW-1:0] n);
    logic [2*DW-1:0] p;
    p = {{DW{1'b0}}, t} * {{DW{1'b0}}, n};
    case (op)
      3'd2: return t + n;
      3'd3: return t - n;
      default: return p[DW-1:0];
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    pre_en = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_en = 1'b0;
  endtask

  // issue one instruction, check ports against the bench model, update model
  task automatic run(input logic [2:0] op, input logic [AW-1:0] a);
    logic e_ovf, e_udf, e_rd, e_wr;
    int e_busy, bc;
    logic [DW-1:0] e_wd, pv;
    string rq;
    logic s_ovf, s_udf, s_rd, s_wr;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_wd;
    e_ovf = 0; e_udf = 0; e_rd = 0; e_wr = 0; e_busy = 0; e_wd = '0; pv = '0;
    case (op)
      3'd0: begin
        rq = "R2";
        if (m_cnt == DEPTH) begin e_ovf = 1; rq = "R3"; end
        else begin e_rd = 1; e_busy = 2; pv = bmem[a]; end
      end
      3'd1: begin
        rq = "R4";
        if (m_cnt == 0) begin e_udf = 1; rq = "R5"; end
        else begin e_wr = 1; e_busy = 1; e_wd = m_stk[m_cnt-1]; end
      end
      3'd2, 3'd3, 3'd4: begin
        rq = (op == 3'd2) ? "R6" : (op == 3'd3) ? "R7" : "R8";
        if (m_cnt < 2) begin e_udf = 1; rq = "R9"; end
      end
      default: rq = "R10";
    endcase
    @(negedge clk);
    while (busy) @(negedge clk);
    instr_valid = 1'b1; instr_op = op; instr_addr = a;
    @(negedge clk);
    instr_valid = 1'b0;
    s_ovf = overflow; s_udf = underflow; s_rd = mem_rd_en; s_wr = mem_wr_en;
    s_addr = mem_addr; s_wd = mem_wdata;
    bc = 0;
    while (busy) begin bc++; @(negedge clk); end
    check({rq, " overflow (R11 clear)"}, {31'd0, s_ovf}, {31'd0, e_ovf});
    check({rq, " underflow (R11 clear)"}, {31'd0, s_udf}, {31'd0, e_udf});
    check({rq, " busy cycles"}, bc, e_busy);
    check({rq, " read strobe"}, {31'd0, s_rd}, {31'd0, e_rd});
    check({rq, " write strobe"}, {31'd0, s_wr}, {31'd0, e_wr});
    if (e_rd || e_wr) check({rq, " address"}, {24'd0, s_addr}, {24'd0, a});
    if (e_wr) check({rq, " pop data"}, s_wd, e_wd);
    if (op == 3'd0 && !e_ovf) begin m_stk[m_cnt] = pv; m_cnt++; end
    else if (op == 3'd1 && !e_udf) m_cnt--;
    else if ((op == 3'd2 || op == 3'd3 || op == 3'd4) && !e_udf) begin
      m_stk[m_cnt-2] = f_alu(op, m_stk[m_cnt-1], m_stk[m_cnt-2]);
      m_cnt--;
    end
  endtask

  task automatic drain();
    while (m_cnt > 0) run(3'd1, 8'd250);
  endtask

  initial begin
    logic [DW-1:0] sent;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 flags", {30'd0, overflow, underflow}, 32'd0);
    check("R1 strobes", {30'd0, mem_rd_en, mem_wr_en}, 32'd0);
    run(3'd1, 8'd1);  // R1/R5: empty after reset -> underflow

    for (int i = 0; i < MWORDS; i++) preload(AW'(i), $urandom);

    // R6 add, R7 sub order, R8 mul truncation
    preload(8'd100, 32'd10); preload(8'd101, 32'd3);
    preload(8'd102, 32'h0001_0000); preload(8'd103, 32'h0001_0003);
    run(3'd0, 8'd100); run(3'd0, 8'd101); run(3'd3, 8'd0); run(3'd1, 8'd110);
    check("R7 top minus next", bmem[110], 32'hFFFF_FFF9);
    run(3'd0, 8'd100); run(3'd0, 8'd101); run(3'd2, 8'd0); run(3'd1, 8'd111);
    check("R6 sum", bmem[111], 32'd13);
    run(3'd0, 8'd102); run(3'd0, 8'd103); run(3'd4, 8'd0); run(3'd1, 8'd112);
    check("R8 low product", bmem[112], 32'h0003_0000);

    // R9: arithmetic with one word refused, word kept
    run(3'd0, 8'd100); run(3'd2, 8'd0); run(3'd1, 8'd113);
    check("R9 word kept", bmem[113], 32'd10);

    // R3: fill, refused push, contents intact; R11: next accept clears flag
    for (int i = 0; i < DEPTH; i++) run(3'd0, AW'(120 + i));
    run(3'd0, 8'd5);
    run(3'd1, 8'd114);
    check("R3 top intact", bmem[114], bmem[127]);
    drain();

    // R10: instruction offered while busy is ignored
    preload(8'd20, 32'hCAFE_0020); preload(8'd30, 32'h5EB7_0030);
    @(negedge clk);
    instr_valid = 1'b1; instr_op = 3'd0; instr_addr = 8'd20;
    @(negedge clk);
    instr_op = 3'd1; instr_addr = 8'd30;
    check("R10 busy on push", {31'd0, busy}, 32'd1);
    @(negedge clk);
    check("R10 no write while busy", {31'd0, mem_wr_en}, 32'd0);
    @(negedge clk);
    instr_valid = 1'b0;
    check("R10 no write after", {30'd0, mem_wr_en, busy}, 32'd0);
    check("R10 memory untouched", bmem[30], 32'h5EB7_0030);
    m_stk[m_cnt] = 32'hCAFE_0020; m_cnt++;
    run(3'd5, 8'd30);  // R10: no-effect opcode
    run(3'd7, 8'd30);
    run(3'd1, 8'd31);
    check("R10 stack after ignored", bmem[31], 32'hCAFE_0020);

    // R12: expression program
    preload(8'd10, 32'd3); preload(8'd11, 32'd5); preload(8'd12, 32'd7);
    preload(8'd13, 32'd11); preload(8'd14, 32'd2); preload(8'd15, 32'd13);
    run(3'd0, 8'd14); run(3'd0, 8'd12); run(3'd0, 8'd13); run(3'd4, 8'd0);
    run(3'd0, 8'd11); run(3'd2, 8'd0); run(3'd3, 8'd0); run(3'd0, 8'd15);
    run(3'd2, 8'd0); run(3'd0, 8'd10); run(3'd2, 8'd0); run(3'd1, 8'd10);
    check("R12 expression result", bmem[10], 32'd96);
    check("R12 stack empty", m_cnt, 32'd0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4)      run(3'd0, AW'($urandom_range(0, 199)));
      else if (r < 6) run(3'd1, AW'($urandom_range(0, 199)));
      else if (r < 9) run(3'($urandom_range(2, 4)), 8'd0);
      else            run(3'($urandom_range(5, 7)), 8'd0);
    end
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule